// File: doc/BRIEF.md
# Streaming Scratch-RAM Port

This block gives a processor streaming access to a small scratch memory over a shared byte-wide bus. The processor presents a device-select code, a read/write level and a data byte each clock. One select code presets an internal address pointer from the data byte. A second select code either stores the data byte into memory or returns the stored byte at the pointer. Every data access moves the pointer on by one location, so a run of bytes can be moved after a single address setup.

Reads return one clock later on a read-data output, qualified by a one-cycle valid flag. The pointer is visible on its own output so that it can be observed. All other select codes leave the block untouched.

Top module: `ramport_ctrl`

## Requirements
- R1: After a synchronous reset, `cur_addr` is 0 and `rd_valid` is 0.
- R2: With `dev_sel` = 4 and `wr` = 1 at a clock edge, `cur_addr` takes the value of `bus_in` after that edge. The load does not advance the pointer, so the next data access uses exactly the loaded location.
- R3: With `dev_sel` = 1 and `wr` = 1 at a clock edge, `bus_in` is stored at location `cur_addr`, and `cur_addr` increases by one after that edge.
- R4: With `dev_sel` = 1 and `wr` = 0 at a clock edge, `rd_data` after that edge holds the byte stored at the pre-edge `cur_addr`, `rd_valid` is 1, and `cur_addr` increases by one.
- R5: The pointer wraps from 255 to 0 on a data access. A data access at 255 reaches location 255, and the next one reaches location 0.
- R6: Any select code other than 1 or 4, and code 4 with `wr` = 0, changes neither the memory contents nor `cur_addr`. `rd_valid` is 0 after such a cycle.
- R7: `rd_valid` is 1 only in the cycle that follows a read access. It is 0 after any cycle that is not a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dev_sel | input | 4 | Device-select code (4 = address preset, 1 = data access) |
| wr | input | 1 | 1 = write, 0 = read |
| bus_in | input | 8 | Byte from the processor (address or data) |
| rd_data | output | 8 | Byte read from memory |
| rd_valid | output | 1 | High for one cycle when `rd_data` carries a fresh read |
| cur_addr | output | 8 | Current value of the address pointer |

## Verification
The bench targets the pointer boundary: it writes and reads across the 255-to-0 wrap. A design that saturated the pointer, or wrapped one step early, would return bytes from the wrong locations. A load followed directly by a read checks that the preset does not also step the pointer; a design that stepped on load would skip the first byte. The bench then sweeps every unused select code, plus the preset code with `wr` low, while `bus_in` carries a distinct pattern. A sloppy decoder would move the pointer or corrupt a stored byte, and the later read-back shows either fault. `rd_valid` is sampled on the cycle after a burst ends, to catch a flag that stays high.

// File: rtl/ramport_pkg.sv
package ramport_pkg;

    localparam int unsigned DEF_DATA_W   = 8;
    localparam int unsigned DEF_ADDR_W   = 8;
    localparam int unsigned DEF_SEL_W    = 4;
    localparam int unsigned DEF_SEL_ADDR = 4;
    localparam int unsigned DEF_SEL_DATA = 1;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } op_e;

    // Map decoded select hits and the direction level to one operation.
    function automatic op_e classify(input logic hit_addr, input logic hit_data,
                                     input logic is_write);
        op_e r;
        r = OP_IDLE;
        if (hit_addr && is_write)
            r = OP_LOAD;
        else if (hit_data)
            r = is_write ? OP_WRITE : OP_READ;
        return r;
    endfunction

endpackage

// File: rtl/ramport_decode.sv
module ramport_decode
    import ramport_pkg::*;
#(
    parameter int unsigned SEL_W    = DEF_SEL_W,
    parameter int unsigned SEL_ADDR = DEF_SEL_ADDR,
    parameter int unsigned SEL_DATA = DEF_SEL_DATA
) (
    input  logic [SEL_W-1:0] dev_sel,
    input  logic             wr,
    output op_e              op
);
    localparam logic [SEL_W-1:0] CODE_ADDR = SEL_W'(SEL_ADDR);
    localparam logic [SEL_W-1:0] CODE_DATA = SEL_W'(SEL_DATA);

    logic hit_addr;
    logic hit_data;

    always_comb begin
        hit_addr = (dev_sel == CODE_ADDR);
        hit_data = (dev_sel == CODE_DATA);
        op       = classify(hit_addr, hit_data, wr);
    end
endmodule

// File: rtl/ramport_addr_ctr.sv
module ramport_addr_ctr #(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] q
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= load_val;          // preset wins, no step
        else if (step)
            q <= q + ONE;           // natural wrap at the top
    end
endmodule

// File: rtl/ramport_mem.sv
module ramport_mem #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            store[addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= re;
            if (re)
                rdata <= store[addr];
        end
    end
endmodule

// File: rtl/ramport_ctrl.sv
module ramport_ctrl
    import ramport_pkg::*;
#(
    parameter int unsigned DATA_W   = DEF_DATA_W,
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter int unsigned SEL_W    = DEF_SEL_W,
    parameter int unsigned SEL_ADDR = DEF_SEL_ADDR,
    parameter int unsigned SEL_DATA = DEF_SEL_DATA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  dev_sel,
    input  logic              wr,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] cur_addr
);
    op_e  op;
    logic do_load;
    logic do_write;
    logic do_read;

    ramport_decode #(
        .SEL_W   (SEL_W),
        .SEL_ADDR(SEL_ADDR),
        .SEL_DATA(SEL_DATA)
    ) u_dec (
        .dev_sel(dev_sel),
        .wr     (wr),
        .op     (op)
    );

    always_comb begin
        do_load  = (op == OP_LOAD);
        do_write = (op == OP_WRITE);
        do_read  = (op == OP_READ);
    end

    ramport_addr_ctr #(
        .ADDR_W(ADDR_W)
    ) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .load    (do_load),
        .step    (do_write | do_read),
        .load_val(bus_in[ADDR_W-1:0]),
        .q       (cur_addr)
    );

    ramport_mem #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (do_write),
        .re    (do_read),
        .addr  (cur_addr),
        .wdata (bus_in),
        .rdata (rd_data),
        .rvalid(rd_valid)
    );
endmodule

// File: rtl/ramport_ctrl_chk.sv
module ramport_ctrl_chk #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned SEL_W    = 4,
    parameter int unsigned SEL_ADDR = 4,
    parameter int unsigned SEL_DATA = 1
) (
    input logic              clk,
    input logic              rst,
    input logic [SEL_W-1:0]  dev_sel,
    input logic              wr,
    input logic [DATA_W-1:0] bus_in,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] cur_addr
);
    localparam logic [SEL_W-1:0]  C_ADDR = SEL_W'(SEL_ADDR);
    localparam logic [SEL_W-1:0]  C_DATA = SEL_W'(SEL_DATA);
    localparam logic [ADDR_W-1:0] ONE    = ADDR_W'(1);

    AST_RESET_STATE: assert property (@(posedge clk) $past(rst) |-> (cur_addr == '0 && !rd_valid)); // R1

    AST_LOAD_TAKES_BUS: assert property (@(posedge clk) disable iff (rst)
        (dev_sel == C_ADDR && wr) |=> (cur_addr == $past(bus_in[ADDR_W-1:0]))); // R2

    AST_ACCESS_STEPS: assert property (@(posedge clk) disable iff (rst)
        (dev_sel == C_DATA) |=> (cur_addr == ADDR_W'($past(cur_addr) + ONE))); // R5

    AST_OTHER_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (dev_sel != C_DATA && !(dev_sel == C_ADDR && wr)) |=> $stable(cur_addr)); // R6

    AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        (dev_sel == C_DATA && !wr) |=> rd_valid); // R4

    AST_VALID_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        !(dev_sel == C_DATA && !wr) |=> !rd_valid); // R7
endmodule

bind ramport_ctrl ramport_ctrl_chk #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .SEL_W   (SEL_W),
    .SEL_ADDR(SEL_ADDR),
    .SEL_DATA(SEL_DATA)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .dev_sel (dev_sel),
    .wr      (wr),
    .bus_in  (bus_in),
    .rd_valid(rd_valid),
    .cur_addr(cur_addr)
);

// File: tb/sim_ramport_ctrl.sv
`timescale 1ns/1ps
module sim_ramport_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] dev_sel;
    logic       wr;
    logic [7:0] bus_in;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic [7:0] cur_addr;

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    logic [7:0] ref_mem [256];
    logic [7:0] ref_ptr;

    always #2 clk = ~clk;   // 250 MHz

    ramport_ctrl u0 (
        .clk(clk), .rst(rst), .dev_sel(dev_sel), .wr(wr), .bus_in(bus_in),
        .rd_data(rd_data), .rd_valid(rd_valid), .cur_addr(cur_addr)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one bus cycle at the falling edge, sample just after the rising edge.
    task automatic cyc(input logic [3:0] s, input logic w, input logic [7:0] d);
        @(negedge clk);
        dev_sel = s; wr = w; bus_in = d;
        @(posedge clk);
        #1;
    endtask

    task automatic load_ptr(input logic [7:0] a);
        cyc(4'd4, 1'b1, a);
        ref_ptr = a;
        check8("R2 load", cur_addr, a);
    endtask

    task automatic put(input logic [7:0] d);
        cyc(4'd1, 1'b1, d);
        ref_mem[ref_ptr] = d;
        ref_ptr = ref_ptr + 8'd1;
        check8("R3 write step", cur_addr, ref_ptr);
        check8("R7 no valid on write", {7'd0, rd_valid}, 8'd0);
    endtask

    task automatic get(input string req);
        logic [7:0] exp;
        exp = ref_mem[ref_ptr];
        cyc(4'd1, 1'b0, 8'h00);
        ref_ptr = ref_ptr + 8'd1;
        check8({req, " R4 data"}, rd_data, exp);
        check8("R4 valid", {7'd0, rd_valid}, 8'd1);
        check8("R4 read step", cur_addr, ref_ptr);
    endtask

    task automatic t_reset;
        rst = 1'b1; dev_sel = 4'd0; wr = 1'b0; bus_in = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        ref_ptr = 8'h00;
        check8("R1 pointer", cur_addr, 8'h00);
        check8("R1 valid", {7'd0, rd_valid}, 8'd0);
    endtask

    task automatic t_burst;
        load_ptr(8'h10);
        put(8'h3C); put(8'hA5); put(8'h00); put(8'hFF);
        load_ptr(8'h10);                 // R2: first read hits 0x10 itself
        for (int i = 0; i < 4; i++) get("R2/R3 burst");
        cyc(4'd0, 1'b0, 8'h00);
        check8("R7 valid drops", {7'd0, rd_valid}, 8'd0);
    endtask

    task automatic t_wrap;
        load_ptr(8'hFE);
        put(8'h11); put(8'h22);
        check8("R5 wrap to 0", cur_addr, 8'h00);
        put(8'h33);
        load_ptr(8'hFE);
        get("R5"); get("R5");
        check8("R5 read wrap", cur_addr, 8'h00);
        get("R5");
    endtask

    task automatic t_ignored;
        load_ptr(8'h40);
        put(8'h6E);
        load_ptr(8'h40);
        for (int c = 0; c < 16; c++) begin
            if (c != 1 && c != 4) begin
                cyc(4'(c), 1'b1, 8'h99);
                check8("R6 pointer held", cur_addr, 8'h40);
                check8("R6 no valid", {7'd0, rd_valid}, 8'd0);
                cyc(4'(c), 1'b0, 8'h99);
                check8("R6 pointer held rd", cur_addr, 8'h40);
            end
        end
        cyc(4'd4, 1'b0, 8'h99);           // preset code with read level
        check8("R6 preset needs write", cur_addr, 8'h40);
        check8("R6 no valid", {7'd0, rd_valid}, 8'd0);
        get("R6 memory intact");
    endtask

    initial begin
        t_reset();
        t_burst();
        t_wrap();
        t_ignored();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule